// File: doc/BRIEF.md
# Predicated Vector Shift-Insert Unit

The unit merges shifted bits of a source vector into a destination vector, lane by lane, for 128-bit vectors split into 8, 16 or 32-bit lanes. In right-insert mode every source lane is logically shifted right. The shifted value replaces the low part of the destination lane, and the top shift-count bits of the destination lane are kept. In left-insert mode the source lane is shifted left. The shifted value replaces the destination bits from the shift position up to the lane MSB, and the low shift-count bits are kept. All lanes use the same shift count, and no bit moves from one lane into another.

A 16-bit byte predicate then decides, byte by byte, whether the merged value or the old destination byte appears in the result. Two shift counts are defined as no-ops: zero in left-insert mode, and the full lane width in right-insert mode. A count outside the legal range, or a reserved lane-size code, marks the operation illegal. In both of these cases the write-back is suppressed.

Operations are accepted through a valid/ready handshake. The registered result appears one clock after acceptance, together with a write-enable, an illegal flag and a one-cycle pulse. The pulse tells the external predicate sequencer to step after every accepted operation.

Top module: `vsi_unit`

## Requirements
- R1: `esz_i` selects the lane width: 0 gives 8 bits, 1 gives 16 bits and 2 gives 32 bits. Code 3 is reserved. Shifts never move a bit across a lane boundary.
- R2: With `dir_i`=0 (right-insert) and a count s in 1..W-1, each result lane is the source lane shifted right by s in its low W-s bits, and the destination lane in its top s bits.
- R3: With `dir_i`=1 (left-insert) and a count s in 1..W-1, each result lane is the source lane shifted left by s in bits s..W-1, and the destination lane in its low s bits.
- R4: A count of 0 in left-insert mode, or of W in right-insert mode, returns the destination unchanged, with `wr_en_o`=0 and `illegal_o`=0.
- R5: A count of 0 or above W in right-insert mode, a count of W or more in left-insert mode, or `esz_i`=3 gives `illegal_o`=1 and `wr_en_o`=0, and returns the destination unchanged.
- R6: Predicate bit i governs result bits 8i+7..8i. When the bit is set the byte takes the merged value, and when it is clear the byte keeps the destination byte.
- R7: `advance_o` is high for exactly one cycle, the cycle after each accepted operation, including no-op and illegal ones.
- R8: The result and its flags are registered and valid in the cycle after acceptance. While `out_valid_o`=1 and `out_ready_i`=0 they hold steady, and `in_ready_o` equals `!out_valid_o || out_ready_i`.
- R9: Reset clears `out_valid_o` and `advance_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation offered |
| in_ready_o | output | 1 | Operation can be taken |
| dst_i | input | 128 | Destination vector (old contents) |
| src_i | input | 128 | Source vector |
| esz_i | input | 2 | Lane width code |
| dir_i | input | 1 | 0 right-insert, 1 left-insert |
| shamt_i | input | 6 | Shift count |
| pred_i | input | 16 | Per-byte write predicate |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Result consumed |
| result_o | output | 128 | Merged vector |
| wr_en_o | output | 1 | Write back the result |
| illegal_o | output | 1 | Illegal operation |
| advance_o | output | 1 | Predicate step pulse |

## Verification
All results are due exactly one clock after the accepting edge. The bench drives inputs on the falling edge, so acceptance happens at the next rising edge, and it samples result, flags and pulse at the falling edge that follows. For the stall case it samples one more falling edge later, to see the held result and the pulse already low. Expected lane data are computed bit by bit from the requirement text, not from masks or shifts of the design's form.

// File: rtl/vsi_pkg.sv
package vsi_pkg;
  localparam int unsigned SHAMT_W = 6;
  localparam int unsigned BYTE_W  = 8;

  typedef enum logic [1:0] {ESZ_B = 2'd0, ESZ_H = 2'd1, ESZ_W = 2'd2, ESZ_RSVD = 2'd3} esz_e;
  typedef enum logic {DIR_RIGHT = 1'b0, DIR_LEFT = 1'b1} dir_e;
  typedef enum logic [1:0] {OP_EXEC = 2'd0, OP_NOOP = 2'd1, OP_ILLEGAL = 2'd2} op_class_e;

  function automatic logic [SHAMT_W:0] esz_bits(esz_e e);
    case (e)
      ESZ_B:   return (SHAMT_W+1)'(8);
      ESZ_H:   return (SHAMT_W+1)'(16);
      ESZ_W:   return (SHAMT_W+1)'(32);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/vsi_classify.sv
module vsi_classify
  import vsi_pkg::*;
(
  input  esz_e                esz_i,
  input  dir_e                dir_i,
  input  logic [SHAMT_W-1:0]  shamt_i,
  output op_class_e           cls_o
);
  logic [SHAMT_W:0] w;
  logic [SHAMT_W:0] s;

  always_comb begin
    w = esz_bits(esz_i);
    s = {1'b0, shamt_i};
    if (w == '0) begin
      cls_o = OP_ILLEGAL;
    end else if (dir_i == DIR_LEFT) begin
      if (s >= w)          cls_o = OP_ILLEGAL;
      else if (s == '0)    cls_o = OP_NOOP;
      else                 cls_o = OP_EXEC;
    end else begin
      if (s == '0 || s > w) cls_o = OP_ILLEGAL;
      else if (s == w)      cls_o = OP_NOOP;
      else                  cls_o = OP_EXEC;
    end
  end
endmodule

// File: rtl/vsi_mask_gen.sv
module vsi_mask_gen
  import vsi_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  esz_e                esz_i,
  input  dir_e                dir_i,
  input  logic [SHAMT_W-1:0]  shamt_i,
  output logic [VEC_W-1:0]    mask_o
);
  localparam int unsigned NUM_SZ = 3;

  logic [VEC_W-1:0] rep [NUM_SZ];

  for (genvar g = 0; g < NUM_SZ; g++) begin : g_sz
    localparam int unsigned LW = BYTE_W << g;
    logic [LW-1:0] lane_m;
    // one lane's insert mask, then copied to every lane of that width
    always_comb begin
      lane_m = '1;
      if (dir_i == DIR_LEFT) lane_m = lane_m << shamt_i;
      else                   lane_m = lane_m >> shamt_i;
    end
    assign rep[g] = {(VEC_W/LW){lane_m}};
  end

  always_comb begin
    case (esz_i)
      ESZ_B:   mask_o = rep[0];
      ESZ_H:   mask_o = rep[1];
      default: mask_o = rep[2];
    endcase
  end
endmodule

// File: rtl/vsi_lane_shift.sv
module vsi_lane_shift
  import vsi_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic [VEC_W-1:0]    src_i,
  input  esz_e                esz_i,
  input  dir_e                dir_i,
  input  logic [SHAMT_W-1:0]  shamt_i,
  output logic [VEC_W-1:0]    shifted_o
);
  localparam int unsigned NUM_SZ = 3;

  logic [VEC_W-1:0] shv [NUM_SZ];

  for (genvar g = 0; g < NUM_SZ; g++) begin : g_sz
    localparam int unsigned LW    = BYTE_W << g;
    localparam int unsigned LANES = VEC_W / LW;
    logic [LW-1:0] lane_out [LANES];
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_out[l] = (dir_i == DIR_LEFT) ? (src_i[l*LW +: LW] << shamt_i)
                                               : (src_i[l*LW +: LW] >> shamt_i);
    end
    always_comb begin
      for (int l = 0; l < LANES; l++) shv[g][l*LW +: LW] = lane_out[l];
    end
  end

  always_comb begin
    case (esz_i)
      ESZ_B:   shifted_o = shv[0];
      ESZ_H:   shifted_o = shv[1];
      default: shifted_o = shv[2];
    endcase
  end
endmodule

// File: rtl/vsi_pred_merge.sv
module vsi_pred_merge
  import vsi_pkg::*;
#(
  parameter int unsigned VEC_W = 128,
  localparam int unsigned NB   = VEC_W / BYTE_W
) (
  input  logic [VEC_W-1:0] ins_i,
  input  logic [VEC_W-1:0] dst_i,
  input  logic [NB-1:0]    pred_i,
  input  logic             en_i,
  output logic [VEC_W-1:0] out_o
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign out_o[b*BYTE_W +: BYTE_W] = (en_i && pred_i[b]) ? ins_i[b*BYTE_W +: BYTE_W]
                                                           : dst_i[b*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/vsi_unit.sv
module vsi_unit
  import vsi_pkg::*;
#(
  parameter int unsigned VEC_W = 128,
  localparam int unsigned NB   = VEC_W / BYTE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [VEC_W-1:0]   dst_i,
  input  logic [VEC_W-1:0]   src_i,
  input  logic [1:0]         esz_i,
  input  logic               dir_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic [NB-1:0]      pred_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [VEC_W-1:0]   result_o,
  output logic               wr_en_o,
  output logic               illegal_o,
  output logic               advance_o
);
  esz_e             esz;
  dir_e             dir;
  op_class_e        cls;
  logic [VEC_W-1:0] mask, shifted, ins, merged;
  logic             accept;
  logic             valid_q, we_q, ill_q, adv_q;
  logic [VEC_W-1:0] res_q;

  assign esz = esz_e'(esz_i);
  assign dir = dir_e'(dir_i);

  vsi_classify u_cls (
    .esz_i(esz), .dir_i(dir), .shamt_i(shamt_i), .cls_o(cls)
  );

  vsi_mask_gen #(.VEC_W(VEC_W)) u_mask (
    .esz_i(esz), .dir_i(dir), .shamt_i(shamt_i), .mask_o(mask)
  );

  vsi_lane_shift #(.VEC_W(VEC_W)) u_shift (
    .src_i(src_i), .esz_i(esz), .dir_i(dir), .shamt_i(shamt_i), .shifted_o(shifted)
  );

  assign ins = (shifted & mask) | (dst_i & ~mask);

  vsi_pred_merge #(.VEC_W(VEC_W)) u_merge (
    .ins_i(ins), .dst_i(dst_i), .pred_i(pred_i),
    .en_i(cls == OP_EXEC), .out_o(merged)
  );

  assign in_ready_o = !valid_q || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      adv_q   <= 1'b0;
      we_q    <= 1'b0;
      ill_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      adv_q <= accept;
      if (accept) begin
        valid_q <= 1'b1;
        res_q   <= merged;
        we_q    <= (cls == OP_EXEC);
        ill_q   <= (cls == OP_ILLEGAL);
      end else if (out_ready_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign out_valid_o = valid_q;
  assign result_o    = res_q;
  assign wr_en_o     = we_q;
  assign illegal_o   = ill_q;
  assign advance_o   = adv_q;
endmodule

// File: rtl/vsi_unit_chk.sv
module vsi_unit_chk #(
  parameter int unsigned VEC_W = 128,
  localparam int unsigned NB   = VEC_W / 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [VEC_W-1:0] dst_i,
  input logic [1:0]       esz_i,
  input logic             dir_i,
  input logic [5:0]       shamt_i,
  input logic [NB-1:0]    pred_i,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [VEC_W-1:0] result_o,
  input logic             wr_en_o,
  input logic             illegal_o,
  input logic             advance_o
);
  logic       acc, bad_in, noop_in;
  logic [6:0] w_in;

  assign acc = in_valid_i && in_ready_o;

  always_comb begin
    case (esz_i)
      2'd0:    w_in = 7'd8;
      2'd1:    w_in = 7'd16;
      2'd2:    w_in = 7'd32;
      default: w_in = 7'd0;
    endcase
    bad_in  = (w_in == 7'd0) ||
              (dir_i ? ({1'b0, shamt_i} >= w_in)
                     : (shamt_i == 6'd0 || {1'b0, shamt_i} > w_in));
    noop_in = !bad_in && (dir_i ? (shamt_i == 6'd0) : ({1'b0, shamt_i} == w_in));
  end

  assert_noop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && noop_in |=> !wr_en_o && !illegal_o && result_o == $past(dst_i));

  assert_illegal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && bad_in |=> illegal_o && !wr_en_o && result_o == $past(dst_i));

  assert_flags_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !(wr_en_o && illegal_o));

  assert_pred_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && pred_i == '0 |=> result_o == $past(dst_i));

  assert_adv_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> advance_o);

  assert_adv_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !advance_o);

  assert_valid_after_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> out_valid_o);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(result_o) && $stable(wr_en_o)
                                    && $stable(illegal_o));
endmodule

bind vsi_unit vsi_unit_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/vsi_unit_tb_top.sv
`timescale 1ns/1ps
module vsi_unit_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid_i = 1'b0;
  logic         in_ready_o;
  logic [127:0] dst_i = '0;
  logic [127:0] src_i = '0;
  logic [1:0]   esz_i = '0;
  logic         dir_i = 1'b0;
  logic [5:0]   shamt_i = '0;
  logic [15:0]  pred_i = '0;
  logic         out_valid_o;
  logic         out_ready_i = 1'b1;
  logic [127:0] result_o;
  logic         wr_en_o, illegal_o, advance_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  vsi_unit dut_i (.*);

  localparam logic [127:0] DST0 = 128'h00112233_44556677_8899AABB_CCDDEEFF;
  localparam logic [127:0] SRC0 = 128'hFFEEDDCC_BBAA9988_77665544_33221100;
  localparam logic [127:0] DST1 = 128'hDEADBEEF_0BADF00D_CAFEBABE_8BADF00D;
  localparam logic [127:0] SRC1 = 128'h13579BDF_2468ACE0_F0E1D2C3_B4A59687;

  typedef struct packed {
    logic [1:0]  esz;
    logic        dir;
    logic [5:0]  sh;
    logic [15:0] pred;
    logic        pat;
    logic        we;
    logic        ill;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 6'd3,  16'hFFFF, 1'b0, 1'b1, 1'b0},
    '{2'd1, 1'b0, 6'd5,  16'hFFFF, 1'b1, 1'b1, 1'b0},
    '{2'd2, 1'b0, 6'd31, 16'hFFFF, 1'b0, 1'b1, 1'b0},
    '{2'd2, 1'b0, 6'd1,  16'hFFFF, 1'b1, 1'b1, 1'b0},
    '{2'd0, 1'b1, 6'd1,  16'hFFFF, 1'b0, 1'b1, 1'b0},
    '{2'd1, 1'b1, 6'd15, 16'hFFFF, 1'b1, 1'b1, 1'b0},
    '{2'd2, 1'b1, 6'd7,  16'hFFFF, 1'b0, 1'b1, 1'b0},
    '{2'd0, 1'b1, 6'd7,  16'hFFFF, 1'b1, 1'b1, 1'b0},
    '{2'd0, 1'b0, 6'd8,  16'hFFFF, 1'b0, 1'b0, 1'b0},
    '{2'd2, 1'b1, 6'd0,  16'hFFFF, 1'b1, 1'b0, 1'b0},
    '{2'd1, 1'b0, 6'd16, 16'hFFFF, 1'b0, 1'b0, 1'b0},
    '{2'd0, 1'b0, 6'd0,  16'hFFFF, 1'b1, 1'b0, 1'b1},
    '{2'd0, 1'b1, 6'd8,  16'hFFFF, 1'b0, 1'b0, 1'b1},
    '{2'd2, 1'b0, 6'd33, 16'hFFFF, 1'b1, 1'b0, 1'b1},
    '{2'd3, 1'b1, 6'd4,  16'hFFFF, 1'b0, 1'b0, 1'b1},
    '{2'd1, 1'b0, 6'd40, 16'hFFFF, 1'b1, 1'b0, 1'b1},
    '{2'd1, 1'b1, 6'd4,  16'hA5C3, 1'b0, 1'b1, 1'b0},
    '{2'd2, 1'b0, 6'd9,  16'h0000, 1'b1, 1'b1, 1'b0},
    '{2'd0, 1'b0, 6'd2,  16'h0001, 1'b0, 1'b1, 1'b0}
  };

  // bit-level model written from the requirement text
  function automatic logic [127:0] model(input logic [1:0] esz, input logic dir,
                                         input int sh, input logic [15:0] pred,
                                         input logic [127:0] dst, input logic [127:0] src);
    int w;
    logic ill, noop;
    logic [127:0] r;
    w    = (esz == 2'd0) ? 8 : (esz == 2'd1) ? 16 : (esz == 2'd2) ? 32 : 0;
    ill  = (w == 0) || (dir ? (sh >= w) : (sh == 0 || sh > w));
    noop = !ill && (dir ? (sh == 0) : (sh == w));
    if (ill || noop) return dst;
    r = dst;
    for (int l = 0; l < 128 / w; l++) begin
      for (int b = 0; b < w; b++) begin
        if (!dir && b < w - sh) r[l*w + b] = src[l*w + b + sh];
        if (dir && b >= sh)     r[l*w + b] = src[l*w + b - sh];
      end
    end
    for (int k = 0; k < 16; k++)
      if (!pred[k]) r[k*8 +: 8] = dst[k*8 +: 8];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] esz, input logic dir, input logic [5:0] sh,
                       input logic [15:0] pred, input logic [127:0] dst,
                       input logic [127:0] src);
    esz_i = esz; dir_i = dir; shamt_i = sh; pred_i = pred; dst_i = dst; src_i = src;
    in_valid_i = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R9 reset state
    check(out_valid_o == 1'b0, "R9", "out_valid in reset", 128'(out_valid_o), 128'd0);
    check(advance_o == 1'b0,   "R9", "advance in reset",   128'(advance_o),   128'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(in_ready_o == 1'b1, "R8", "ready when idle", 128'(in_ready_o), 128'd1);

    for (int i = 0; i < NV; i++) begin
      logic [127:0] d, s, exp;
      string tag;
      d = VECS[i].pat ? DST1 : DST0;
      s = VECS[i].pat ? SRC1 : SRC0;
      exp = model(VECS[i].esz, VECS[i].dir, int'(VECS[i].sh), VECS[i].pred, d, s);
      if (VECS[i].ill)                tag = "R5";
      else if (!VECS[i].we)           tag = "R4";
      else if (VECS[i].pred != '1)    tag = "R6";
      else if (VECS[i].dir)           tag = "R3";
      else                            tag = "R2";
      drive(VECS[i].esz, VECS[i].dir, VECS[i].sh, VECS[i].pred, d, s);
      @(negedge clk_i);
      in_valid_i = 1'b0;
      check(result_o == exp,         tag,  $sformatf("vec %0d result", i), result_o, exp);
      check(wr_en_o == VECS[i].we,   tag,  $sformatf("vec %0d wr_en", i), 128'(wr_en_o), 128'(VECS[i].we));
      check(illegal_o == VECS[i].ill, tag, $sformatf("vec %0d illegal", i), 128'(illegal_o), 128'(VECS[i].ill));
      check(advance_o && out_valid_o, "R7", $sformatf("vec %0d advance", i),
            128'({advance_o, out_valid_o}), 128'd3);
      @(negedge clk_i);
      check(!advance_o && !out_valid_o, "R7", $sformatf("vec %0d pulse end", i),
            128'({advance_o, out_valid_o}), 128'd0);
    end

    // R1 lanes: all-ones source shifted right by 1 in byte lanes, no carry between lanes
    drive(2'd0, 1'b0, 6'd1, 16'hFFFF, '0, '1);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    check(result_o == {16{8'h7F}}, "R1", "byte lanes isolated", result_o, {16{8'h7F}});
    @(negedge clk_i);
    // R1 16-bit lanes, left by 4
    drive(2'd1, 1'b1, 6'd4, 16'hFFFF, '0, {8{16'hF00F}});
    @(negedge clk_i);
    in_valid_i = 1'b0;
    check(result_o == {8{16'h00F0}}, "R1", "halfword lanes isolated", result_o, {8{16'h00F0}});
    @(negedge clk_i);

    // R8 stall: result held while downstream not ready
    out_ready_i = 1'b0;
    drive(2'd2, 1'b0, 6'd4, 16'hFFFF, DST0, SRC0);
    @(negedge clk_i);
    check(out_valid_o && !in_ready_o, "R8", "stalled valid/ready",
          128'({out_valid_o, in_ready_o}), 128'd2);
    drive(2'd2, 1'b1, 6'd4, 16'hFFFF, DST1, SRC1);
    @(negedge clk_i);
    check(result_o == model(2'd2, 1'b0, 4, 16'hFFFF, DST0, SRC0), "R8", "held result",
          result_o, model(2'd2, 1'b0, 4, 16'hFFFF, DST0, SRC0));
    check(!advance_o, "R7", "single pulse under stall", 128'(advance_o), 128'd0);
    out_ready_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    check(result_o == model(2'd2, 1'b1, 4, 16'hFFFF, DST1, SRC1), "R8", "next op after release",
          result_o, model(2'd2, 1'b1, 4, 16'hFFFF, DST1, SRC1));
    check(advance_o, "R7", "pulse for second op", 128'(advance_o), 128'd1);

    // R9 asynchronous reset mid-operation
    out_ready_i = 1'b0;
    drive(2'd0, 1'b1, 6'd2, 16'hFFFF, DST0, SRC0);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    check(!out_valid_o && !advance_o, "R9", "reset clears outputs",
          128'({out_valid_o, advance_o}), 128'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    out_ready_i = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule